// File: doc/BRIEF.md
# Programmable Counter/Timer

This block is a 16-bit down-counter that sits beside a byte-wide UART register interface. Software writes a 16-bit preload as two bytes, picks a clock source and an operating style through a 3-bit field of the auxiliary control register, and starts or stops the count with command codes written to the command register. Source ticks arrive as single-cycle clock-enable strobes: the input pin, the input pin divided by 16, the transmit clock, the crystal, and the crystal divided by 16.

The block has two modes. In counter mode it performs a one-shot count down from the preload. It raises a ready flag on terminal count and then stays halted. In timer mode it runs without stopping. At each terminal count it reloads from the preload and toggles a square-wave output that other clock-selection logic can use. It raises the ready flag on every second terminal count. The ready flag feeds the interrupt logic as status bit 4. The current count can be read back byte by byte, and the two halves stay coherent.

Top module: `ctr_timer`

## Requirements
- R1: After synchronous reset, `rdy` and `sq_out` are 0, `rdata` is 0 and the count reads back as 0.
- R2: Counter mode (field values 0..3). After a start with preload N-1, `rdy` stays 0 for the first N-1 ticks of the selected source and is 1 right after the Nth tick.
- R3: In counter mode, once terminal count is reached the count stays at 0 and `rdy` stays 1, however many further ticks arrive.
- R4: A write to address 4 sets the source/mode field from `wdata[6:4]`. Field values: 0 pin, 1 pin/16, 2 transmit clock, 3 crystal (counter); 4 pin, 5 pin/16, 6 crystal, 7 crystal/16 (timer). A tick on a source that is not selected leaves the count unchanged.
- R5: A write to address 2 with `wdata[7:4]` = 8 starts the count. It loads the count from the preload, clears `rdy` and clears `sq_out`. The load is visible in the cycle after the write.
- R6: A write to address 2 with `wdata[7:4]` = 9 stops the count. In counter mode it clears `rdy` and halts, so later ticks do not change the count.
- R7: In timer mode with preload N-1, each Nth tick reloads the count from the preload and toggles `sq_out`. `rdy` sets on every second terminal count, which is the one where `sq_out` falls.
- R8: In timer mode the stop command clears `rdy` but the count keeps going.
- R9: A read of address 6 returns the upper count byte on `rdata` one cycle later and captures the lower byte. A read of address 7 returns the lower byte captured by the last read of address 6.
- R10: Writes to the preload bytes (address 6 upper, 7 lower) leave a count in progress untouched. The new value is used at the next start or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| tk_pin | input | 1 | Input-pin tick strobe |
| tk_pin16 | input | 1 | Input-pin/16 tick strobe |
| tk_txc | input | 1 | Transmit-clock tick strobe |
| tk_xtal | input | 1 | Crystal tick strobe |
| tk_xtal16 | input | 1 | Crystal/16 tick strobe |
| rdata | output | 8 | Registered read data |
| rdy | output | 1 | Counter-ready flag (status bit 4) |
| sq_out | output | 1 | Timer square wave |

## Verification
An off-by-one in the terminal-count test moves the rise of `rdy` one source tick early or late. The bench samples `rdy` right after tick N-1 and right after tick N, so this shows up within a single tick. A wrong source decode or a preload that leaks into a running count shows up at the next coherent read pair as an unexpected count byte. A timer that fails to reload, or a phase that is not toggled, shows up within two terminal counts as a wrong `sq_out` level or as `rdy` rising on the wrong edge.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam logic [2:0] A_CMD    = 3'd2;
  localparam logic [2:0] A_AUX    = 3'd4;
  localparam logic [2:0] A_PRE_HI = 3'd6;
  localparam logic [2:0] A_PRE_LO = 3'd7;
  localparam logic [3:0] C_START  = 4'h8;
  localparam logic [3:0] C_STOP   = 4'h9;
  localparam int         NSRC     = 5;

  typedef enum logic [2:0] {
    SRC_PIN    = 3'd0,
    SRC_PIN16  = 3'd1,
    SRC_TXC    = 3'd2,
    SRC_XTAL   = 3'd3,
    SRC_XTAL16 = 3'd4
  } src_e;

  function automatic src_e mode_src(input logic [2:0] m);
    case (m)
      3'd0, 3'd4: mode_src = SRC_PIN;
      3'd1, 3'd5: mode_src = SRC_PIN16;
      3'd2:       mode_src = SRC_TXC;
      3'd3, 3'd6: mode_src = SRC_XTAL;
      default:    mode_src = SRC_XTAL16;
    endcase
  endfunction
endpackage

// File: rtl/ct_regs.sv
module ct_regs import ct_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] preload,
  output logic [2:0]    mode,
  output logic          start_p,
  output logic          stop_p
);
  logic cmd_wr;
  assign cmd_wr  = wr_en && (addr == AW'(A_CMD));
  assign start_p = cmd_wr && (wdata[DW-1 -: 4] == C_START);
  assign stop_p  = cmd_wr && (wdata[DW-1 -: 4] == C_STOP);

  // byte g of the preload lives at address A_PRE_LO - g
  for (genvar g = 0; g < 2; g++) begin : g_pre
    always_ff @(posedge clk) begin
      if (rst) preload[g*DW +: DW] <= '0;
      else if (wr_en && (addr == AW'(A_PRE_LO) - AW'(g)))
        preload[g*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= '0;
    else if (wr_en && (addr == AW'(A_AUX))) mode <= wdata[6:4];
  end
endmodule

// File: rtl/ct_src_sel.sv
module ct_src_sel import ct_pkg::*; (
  input  logic [2:0]      mode,
  input  logic [NSRC-1:0] ticks,
  output logic            tick,
  output logic            timer_m
);
  src_e src;
  assign src     = mode_src(mode);
  assign timer_m = mode[2];

  always_comb begin
    case (src)
      SRC_PIN:    tick = ticks[0];
      SRC_PIN16:  tick = ticks[1];
      SRC_TXC:    tick = ticks[2];
      SRC_XTAL:   tick = ticks[3];
      SRC_XTAL16: tick = ticks[4];
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/ct_core.sv
module ct_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          timer_m,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [CW-1:0] preload,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          rdy,
  output logic          sq
);
  logic halt_now;
  assign halt_now = stop_p && !timer_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
      rdy     <= 1'b0;
      sq      <= 1'b0;
    end else if (start_p) begin
      count   <= preload;
      running <= 1'b1;
      rdy     <= 1'b0;
      sq      <= 1'b0;
    end else begin
      if (stop_p) begin
        rdy <= 1'b0;
        if (!timer_m) running <= 1'b0;
      end
      if (running && tick && !halt_now) begin
        if (count != '0) begin
          count <= count - 1'b1;
        end else if (timer_m) begin
          count <= preload;
          sq    <= ~sq;
          if (sq) rdy <= 1'b1;
        end else begin
          rdy     <= 1'b1;
          running <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer import ct_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 3,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          tk_pin,
  input  logic          tk_pin16,
  input  logic          tk_txc,
  input  logic          tk_xtal,
  input  logic          tk_xtal16,
  output logic [DW-1:0] rdata,
  output logic          rdy,
  output logic          sq_out
);
  logic [CW-1:0]   preload, count;
  logic [2:0]      mode;
  logic            start_p, stop_p, tick, timer_m, running;
  logic [DW-1:0]   snap;
  logic [NSRC-1:0] ticks;

  assign ticks = {tk_xtal16, tk_xtal, tk_txc, tk_pin16, tk_pin};

  ct_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .preload(preload), .mode(mode), .start_p(start_p), .stop_p(stop_p)
  );

  ct_src_sel u_sel (.mode(mode), .ticks(ticks), .tick(tick), .timer_m(timer_m));

  ct_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .timer_m(timer_m),
    .start_p(start_p), .stop_p(stop_p), .preload(preload),
    .count(count), .running(running), .rdy(rdy), .sq(sq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      snap  <= '0;
    end else if (rd_en) begin
      if (addr == AW'(A_PRE_HI)) begin
        rdata <= count[CW-1 -: DW];
        snap  <= count[DW-1:0];
      end else if (addr == AW'(A_PRE_LO)) begin
        rdata <= snap;
      end else begin
        rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/ct_chk.sv
module ct_chk #(
  parameter int CW = 16,
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start_p,
  input logic          stop_p,
  input logic          tick,
  input logic          timer_m,
  input logic          running,
  input logic          rdy,
  input logic          sq,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic [CW-1:0] count,
  input logic [CW-1:0] preload
);
  // R4
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_p && !(running && tick)) |=> $stable(count));

  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (!rdy && count == $past(preload)));

  // R6
  stop_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_p && !timer_m) |=> (!rdy && !running));

  // R2
  term_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdy) && !$past(timer_m)) |-> (count == '0 && !running));

  // R7
  timer_phase_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rdy) && $past(timer_m)) |-> $fell(sq));

  // R9
  read_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(6)) |=> (rdata == $past(count[CW-1 -: DW])));
endmodule

bind ctr_timer ct_chk #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p), .tick(tick),
  .timer_m(timer_m), .running(running), .rdy(rdy), .sq(sq_out),
  .rd_en(rd_en), .addr(addr), .rdata(rdata), .count(count), .preload(preload)
);

// File: tb/tb_ctr_timer.sv
module tb_ctr_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] tk = '0;
  logic [7:0] rdata;
  logic       rdy, sq_out;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  ctr_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tk_pin(tk[0]), .tk_pin16(tk[1]), .tk_txc(tk[2]),
    .tk_xtal(tk[3]), .tk_xtal16(tk[4]), .rdata(rdata), .rdy(rdy),
    .sq_out(sq_out)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compares the read result one cycle after the read strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      exp_t e;
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected read data %02h", "R9", rdata);
      end else begin
        e = exp_q.pop_front();
        if (rdata !== e.val) begin
          n_bad++;
          $display("FAIL %s: rdata %02h expected %02h", e.tag, rdata, e.val);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    @(negedge clk);
    exp_q.push_back(x);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_cnt(input logic [15:0] e, input string tag);
    rd(3'd6, e[15:8], tag);
    rd(3'd7, e[7:0], tag);
  endtask

  task automatic ticks(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tk[src] = 1'b1;
      @(negedge clk);
      tk[src] = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 rdy", rdy, 1'b0);
    chk("R1 sq", sq_out, 1'b0);
    n_cmp++;
    if (rdata !== 8'h00) begin n_bad++; $display("FAIL R1: rdata %02h expected 00", rdata); end
    rd_cnt(16'h0000, "R1");

    // R2 counter from crystal, preload 4 -> ready after 5 ticks
    wr(3'd4, 8'h30);
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h04);
    wr(3'd2, 8'h80);
    rd_cnt(16'h0004, "R5");
    ticks(3, 2);
    rd_cnt(16'h0002, "R2");
    ticks(3, 2);
    chk("R2 early", rdy, 1'b0);
    ticks(3, 1);
    chk("R2 at N", rdy, 1'b1);
    rd_cnt(16'h0000, "R2");
    // R3 halted at terminal count
    ticks(3, 3);
    chk("R3 rdy held", rdy, 1'b1);
    rd_cnt(16'h0000, "R3");

    // R5 start clears ready and loads; R4 unselected sources ignored
    wr(3'd6, 8'h01);
    wr(3'd7, 8'h02);
    wr(3'd2, 8'h80);
    chk("R5 rdy clr", rdy, 1'b0);
    ticks(0, 2); ticks(1, 2); ticks(2, 2); ticks(4, 2);
    rd_cnt(16'h0102, "R4");
    ticks(3, 1);
    rd_cnt(16'h0101, "R4");
    // R4 pin source in counter mode
    wr(3'd4, 8'h00);
    ticks(0, 1);
    ticks(3, 2);
    rd_cnt(16'h0100, "R4");
    wr(3'd4, 8'h30);

    // R10 preload write during count
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h05);
    rd_cnt(16'h0100, "R10");
    wr(3'd2, 8'h80);
    rd_cnt(16'h0005, "R10");

    // R6 stop in counter mode
    wr(3'd7, 8'h01);
    wr(3'd2, 8'h80);
    ticks(3, 2);
    chk("R6 pre", rdy, 1'b1);
    wr(3'd2, 8'h90);
    chk("R6 rdy clr", rdy, 1'b0);
    wr(3'd7, 8'h05);
    wr(3'd2, 8'h80);
    ticks(3, 1);
    wr(3'd2, 8'h90);
    ticks(3, 3);
    rd_cnt(16'h0004, "R6");

    // R7 timer from crystal, preload 2 -> period 3 ticks per phase
    wr(3'd4, 8'h60);
    wr(3'd7, 8'h02);
    wr(3'd2, 8'h80);
    ticks(3, 2);
    chk("R7 sq0", sq_out, 1'b0);
    ticks(3, 1);
    chk("R7 sq1", sq_out, 1'b1);
    chk("R7 rdy0", rdy, 1'b0);
    rd_cnt(16'h0002, "R7");
    ticks(3, 3);
    chk("R7 sq fall", sq_out, 1'b0);
    chk("R7 rdy", rdy, 1'b1);

    // R8 stop in timer mode keeps counting
    wr(3'd2, 8'h90);
    chk("R8 rdy clr", rdy, 1'b0);
    ticks(3, 1);
    rd_cnt(16'h0001, "R8");
    ticks(3, 2);
    chk("R8 sq", sq_out, 1'b1);

    // R4 timer from crystal/16 ignores crystal ticks
    wr(3'd4, 8'h70);
    wr(3'd2, 8'h80);
    ticks(3, 2);
    rd_cnt(16'h0002, "R4");
    ticks(4, 1);
    rd_cnt(16'h0001, "R4");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule